// File: doc/BRIEF.md
# Token-Fired Relational Compare Unit

This block compares two integer operands and returns a single boolean token. It has three independent input streams: left operand, right operand and a command word. Each stream sits behind its own small queue with a valid/ready handshake. The unit fires when a token waits at the head of every input queue and the result queue has room. A firing consumes exactly one token from each input and pushes one result bit. The block works purely in dataflow fashion: nothing happens until every ingredient of an operation has arrived, and streams may arrive in any order.

The command selects one of six relations, evaluated as left-relation-right. A separate flag bit in the command switches between two's-complement and unsigned interpretation. Typical users are conditional-branch and set-if-less sequencing. There, the result bit later chooses between two candidate values, such as the fall-through address and the taken address. That choice is made downstream and is not part of this unit. Command codes that name no relation yield false and are consumed like any other command, so a bad code never blocks the streams.

Top module: `relcmp_unit`

## Requirements
- R1: While and after reset, with no traffic, `lhs_ready`, `rhs_ready` and `cmd_ready` are 1 and `res_valid` is 0.
- R2: Command bits [2:0] = 0 gives lhs == rhs and = 1 gives lhs != rhs. With bit 3 clear the result is the same as with it set.
- R3: Command bits [2:0] = 2 gives lhs > rhs and = 3 gives lhs >= rhs, using the signed interpretation when bit 3 is 0.
- R4: Command bits [2:0] = 4 gives lhs < rhs and = 5 gives lhs <= rhs, using the signed interpretation when bit 3 is 0.
- R5: With command bit 3 set, relations 2 to 5 compare the operands as unsigned numbers.
- R6: Command bits [2:0] = 6 or 7 (for either value of bit 3) produce a false result. The command and operands are consumed, and later operations proceed normally.
- R7: No result is produced unless all three inputs have delivered a token. Each set of three tokens produces exactly one result.
- R8: Each input queue and the result queue hold two tokens. With `res_ready` low, input tokens are accepted until the queues fill, after which the input ready signals drop. Nothing is lost.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_bit` holds its value.
- R10: Results leave in the order in which their input tokens were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lhs_valid | input | 1 | Left operand token offered |
| lhs_ready | output | 1 | Left operand queue has space |
| lhs_data | input | 32 | Left operand value |
| rhs_valid | input | 1 | Right operand token offered |
| rhs_ready | output | 1 | Right operand queue has space |
| rhs_data | input | 32 | Right operand value |
| cmd_valid | input | 1 | Command token offered |
| cmd_ready | output | 1 | Command queue has space |
| cmd_code | input | 4 | Relation in [2:0], unsigned flag in [3] |
| res_valid | output | 1 | Result token available |
| res_ready | input | 1 | Consumer takes the result |
| res_bit | output | 1 | Boolean outcome |

## Verification
On every cycle, the assertions check the following. No queue occupancy goes beyond its depth. A queue head that is offered but not taken stays put, both inside each queue and at the result port. An undefined command that fires never evaluates true. The truth of each relation under both interpretations can only be shown by the bench's scenarios, which use sign-boundary operands. So can the waiting for a missing stream, the fill-and-stall behaviour under backpressure, and the order in which buffered results drain.

// File: rtl/relcmp_pkg.sv
// Package: shared widths and the relation encoding for the compare unit.
// Assumes the command word carries the relation in its low three bits.
package relcmp_pkg;
    localparam int DATA_W   = 32;
    localparam int CMD_W    = 4;
    localparam int UNS_BIT  = 3;
    localparam int Q_DEPTH  = 2;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_GT = 3'd2,
        REL_GE = 3'd3,
        REL_LT = 3'd4,
        REL_LE = 3'd5
    } rel_e;
endpackage

// File: rtl/tok_queue.sv
// Module: small valid/ready token queue (circular buffer).
// Assumes DEPTH >= 1; in_ready depends only on occupancy, so an input never
// waits combinationally on the consumer.
module tok_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          push, pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Handshake decode from occupancy.
    always_comb begin
        in_ready  = (fill != CW'(DEPTH));
        out_valid = (fill != '0);
        out_data  = slot[rd_ptr];
        push      = in_valid && in_ready;
        pop       = out_valid && out_ready;
    end

    // Storage write; contents need no reset since fill guards them.
    always_ff @(posedge clk) begin
        if (push) slot[wr_ptr] <= in_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    // R8: occupancy never exceeds the configured depth.
    a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R9: an offered head that is not taken is held unchanged.
    a_r9_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/rel_eval.sv
// Module: combinational relation evaluator, lhs REL rhs.
// Assumes two's-complement operands unless the unsigned flag is set;
// relation codes outside the defined six return false.
module rel_eval
    import relcmp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CMD_W
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic [CW-1:0] code,
    output logic          verdict
);
    logic is_eq, is_lt;

    // Equality and ordering in the selected interpretation.
    always_comb begin
        is_eq = (lhs == rhs);
        if (code[UNS_BIT]) is_lt = (lhs < rhs);
        else               is_lt = ($signed(lhs) < $signed(rhs));
    end

    // Relation select; unknown codes give false.
    always_comb begin
        case (code[2:0])
            3'(REL_EQ): verdict = is_eq;
            3'(REL_NE): verdict = !is_eq;
            3'(REL_GT): verdict = !is_lt && !is_eq;
            3'(REL_GE): verdict = !is_lt;
            3'(REL_LT): verdict = is_lt;
            3'(REL_LE): verdict = is_lt || is_eq;
            default:    verdict = 1'b0;
        endcase
    end
endmodule

// File: rtl/relcmp_unit.sv
// Module: token-fired compare unit. Fires when lhs, rhs and command heads
// are all present and the result queue has room; consumes one of each.
// Assumes consumers follow valid/ready: data is taken when both are high.
module relcmp_unit
    import relcmp_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int CW    = CMD_W,
    parameter int DEPTH = Q_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lhs_valid,
    output logic          lhs_ready,
    input  logic [DW-1:0] lhs_data,
    input  logic          rhs_valid,
    output logic          rhs_ready,
    input  logic [DW-1:0] rhs_data,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [CW-1:0] cmd_code,
    output logic          res_valid,
    input  logic          res_ready,
    output logic          res_bit
);
    logic          l_v, r_v, c_v, o_room, fire, verdict;
    logic [DW-1:0] l_head, r_head;
    logic [CW-1:0] c_head;

    tok_queue #(.W(DW), .DEPTH(DEPTH)) i_lhs_q (
        .clk(clk), .rst_n(rst_n),
        .in_valid(lhs_valid), .in_ready(lhs_ready), .in_data(lhs_data),
        .out_valid(l_v), .out_ready(fire), .out_data(l_head));

    tok_queue #(.W(DW), .DEPTH(DEPTH)) i_rhs_q (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rhs_valid), .in_ready(rhs_ready), .in_data(rhs_data),
        .out_valid(r_v), .out_ready(fire), .out_data(r_head));

    tok_queue #(.W(CW), .DEPTH(DEPTH)) i_cmd_q (
        .clk(clk), .rst_n(rst_n),
        .in_valid(cmd_valid), .in_ready(cmd_ready), .in_data(cmd_code),
        .out_valid(c_v), .out_ready(fire), .out_data(c_head));

    rel_eval #(.DW(DW), .CW(CW)) i_eval (
        .lhs(l_head), .rhs(r_head), .code(c_head), .verdict(verdict));

    // Firing rule: every input head present and result space available.
    always_comb fire = l_v && r_v && c_v && o_room;

    tok_queue #(.W(1), .DEPTH(DEPTH)) i_res_q (
        .clk(clk), .rst_n(rst_n),
        .in_valid(fire), .in_ready(o_room), .in_data(verdict),
        .out_valid(res_valid), .out_ready(res_ready), .out_data(res_bit));

    // R6: an undefined relation that fires never yields true.
    a_r6_undef_false: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (c_head[2:1] == 2'b11)) |-> !verdict);

    // R9: result port holds while stalled by the consumer.
    a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_bit)));
endmodule

// File: tb/test_relcmp_unit.sv
module test_relcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lhs_valid = 0, rhs_valid = 0, cmd_valid = 0, res_ready = 0;
    logic [31:0] lhs_data = 0, rhs_data = 0;
    logic [3:0]  cmd_code = 0;
    logic        lhs_ready, rhs_ready, cmd_ready, res_valid, res_bit;
    int          checks = 0, failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    relcmp_unit i_relcmp_unit (
        .clk(clk), .rst_n(rst_n),
        .lhs_valid(lhs_valid), .lhs_ready(lhs_ready), .lhs_data(lhs_data),
        .rhs_valid(rhs_valid), .rhs_ready(rhs_ready), .rhs_data(rhs_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
        .res_valid(res_valid), .res_ready(res_ready), .res_bit(res_bit));

    // {expected, cmd, lhs, rhs}
    localparam int NV = 18;
    localparam logic [68:0] VECS [NV] = '{
        {1'b1, 4'h0, 32'd5, 32'd5},
        {1'b0, 4'h0, 32'd5, 32'd6},
        {1'b1, 4'h1, 32'd5, 32'd6},
        {1'b0, 4'h1, 32'd7, 32'd7},
        {1'b0, 4'h2, 32'hFFFF_FFFF, 32'd1},
        {1'b1, 4'hA, 32'hFFFF_FFFF, 32'd1},
        {1'b1, 4'h3, 32'd3, 32'd3},
        {1'b0, 4'h3, 32'h8000_0000, 32'h7FFF_FFFF},
        {1'b1, 4'hB, 32'h8000_0000, 32'h7FFF_FFFF},
        {1'b1, 4'h4, 32'h8000_0000, 32'd0},
        {1'b0, 4'hC, 32'h8000_0000, 32'd0},
        {1'b1, 4'h5, 32'd4, 32'd4},
        {1'b0, 4'h5, 32'd5, 32'd4},
        {1'b1, 4'hD, 32'd0, 32'hFFFF_FFFF},
        {1'b0, 4'h6, 32'd1, 32'd1},
        {1'b0, 4'hF, 32'd0, 32'd5},
        {1'b1, 4'h8, 32'd9, 32'd9},
        {1'b0, 4'h9, 32'd0, 32'd0}
    };

    function automatic string req_of(input logic [3:0] c);
        if (c[2:0] >= 3'd6)      return "R6";
        if (c[3] && c[2:0] >= 2) return "R5";
        if (c[2:0] <= 3'd1)      return "R2";
        if (c[2:0] <= 3'd3)      return "R3";
        return "R4";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer tokens on the streams picked by mask {cmd, rhs, lhs}.
    task automatic send(input logic [2:0] mask, input logic [3:0] c,
                        input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        while (!((lhs_ready || !mask[0]) && (rhs_ready || !mask[1]) &&
                 (cmd_ready || !mask[2]))) @(negedge clk);
        lhs_valid = mask[0]; lhs_data = a;
        rhs_valid = mask[1]; rhs_data = b;
        cmd_valid = mask[2]; cmd_code = c;
        @(negedge clk);
        lhs_valid = 0; rhs_valid = 0; cmd_valid = 0;
    endtask

    // Wait for a result and take it.
    task automatic take(output logic val, output logic got);
        got = 0; val = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            if (res_valid) got = 1;
            else @(negedge clk);
        end
        if (got) begin
            val = res_bit;
            res_ready = 1;
            @(posedge clk);
            @(negedge clk);
            res_ready = 0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic v, g;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {lhs_ready, rhs_ready, cmd_ready, res_valid}, 4'b1110);
        rst_n = 1;
        @(negedge clk);
        check("R1", {lhs_ready, rhs_ready, cmd_ready, res_valid}, 4'b1110);

        // Vector table: R2..R6
        for (int k = 0; k < NV; k++) begin
            send(3'b111, VECS[k][67:64], VECS[k][63:32], VECS[k][31:0]);
            take(v, g);
            check(req_of(VECS[k][67:64]), {g, v}, {1'b1, VECS[k][68]});
        end

        // R6: undefined code does not stall the next operation
        send(3'b111, 4'h7, 32'd3, 32'd3);
        send(3'b111, 4'h0, 32'd3, 32'd3);
        take(v, g); check("R6", {g, v}, 2'b10);
        take(v, g); check("R6", {g, v}, 2'b11);

        // R7: missing command stream means no result
        send(3'b011, 4'h0, 32'd2, 32'd9);
        repeat (5) @(negedge clk);
        check("R7", res_valid, 0);
        send(3'b100, 4'h4, 32'd0, 32'd0);
        take(v, g); check("R7", {g, v}, 2'b11);
        take(v, g); check("R7", g, 0);

        // R8/R9/R10: fill under backpressure, then drain in order
        send(3'b111, 4'h0, 32'd1, 32'd1);            // 1
        send(3'b111, 4'h0, 32'd1, 32'd2);            // 0
        send(3'b111, 4'h4, 32'hFFFF_FFFF, 32'd0);    // 1
        send(3'b111, 4'hB, 32'd0, 32'd1);            // 0
        repeat (3) @(negedge clk);
        check("R8", {lhs_ready, rhs_ready, cmd_ready}, 3'b000);
        check("R9", {res_valid, res_bit}, 2'b11);
        repeat (3) @(negedge clk);
        check("R9", {res_valid, res_bit}, 2'b11);
        take(v, g); check("R10", {g, v}, 2'b11);
        take(v, g); check("R10", {g, v}, 2'b10);
        take(v, g); check("R10", {g, v}, 2'b11);
        take(v, g); check("R10", {g, v}, 2'b10);
        take(v, g); check("R7", g, 0);
        check("R8", {lhs_ready, rhs_ready, cmd_ready}, 3'b111);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule